// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block sits between a large set of peripheral interrupt request lines and a CPU that has only a few interrupt inputs. Requests are organised into groups of eight. Each group owns one CPU interrupt line. A rising edge on a request line latches a per-source flag. A per-source enable bit decides whether that flag counts toward its group's line. A per-group acknowledge bit blocks the line once the CPU has taken an interrupt from the group, and it stays set until software clears it.

When the CPU services line L, it issues a vector fetch for L. The block picks the lowest-numbered pending enabled source in that group and returns that source's entry from a writable vector table one cycle later. The same fetch clears the source's flag and sets the group's acknowledge bit. Software traps by number return the vector of the first source of the named group. Trap number 0 has no table entry and is reported as invalid. A global enable input turns the whole expansion on or off.

Three more CPU lines bypass the grouping. Line 13 comes from a selectable multiplexer: either timer 1 or the external non-maskable input. Line 14 comes straight from timer 2. The external non-maskable input also drives the CPU NMI output directly.

Top module: `pie_expander`

## Requirements
- R1: After reset, `cpu_int_o`, `vec_vld_o` and `trap_bad_o` are 0. All flags, source enables, acknowledge bits and vector entries are cleared.
- R2: A source flag is set only by a 0-to-1 transition of its request line. Source s (0..7) of line L (1..12) is `irq_i` bit (L-1)*8+s. A request held high does not set the flag again after a fetch has cleared it.
- R3: `cpu_int_o` bit L-1 is high, from the cycle after the edge that set a flag, exactly when the global enable is high, some flag of group L has its enable bit set, and the group's acknowledge bit is clear. Enable bits are written as a whole byte per line through `ier_we_i`/`ier_line_i`/`ier_data_i`, with bit s for source s.
- R4: A fetch for a line whose output is high returns, in the next cycle, `vec_vld_o`=1 and table entry (L-1)*8+s for the lowest-numbered pending enabled source s. That source's flag is cleared, and `vec_vld_o` lasts one cycle.
- R5: A successful fetch sets the group's acknowledge bit, which forces the group's line low. Only an acknowledge write with bit L-1 of `ack_data_i` at 1 clears it. A 0 in that position leaves it unchanged.
- R6: With the global enable high, trap n for n in 1..12 returns table entry (n-1)*8 with `vec_vld_o`=1 in the next cycle. A trap changes no flag or acknowledge bit. A trap presented together with a fetch is dropped.
- R7: With the global enable high, trap 0, or trap 13 to 15, pulses `trap_bad_o` for one cycle and does not raise `vec_vld_o`.
- R8: With the global enable low, `cpu_int_o` is 0. Fetches and traps produce neither `vec_vld_o` nor `trap_bad_o`. Flags and acknowledge bits are kept and reappear when the enable returns.
- R9: `int13_o` follows `xnmi_i` when `int13_sel_i`=1 and follows `tint1_i` when it is 0. `int14_o` follows `tint2_i`. `nmi_o` follows `xnmi_i`.
- R10: A fetch for a line whose output is low (nothing pending and enabled, or already acknowledged, or a line number outside 1..12) returns no vector and changes no acknowledge bit.
- R11: A table write stores `vec_data_i` at `vec_idx_i` when the index is below 96. Writes at higher indices change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global expansion enable |
| irq_i | input | 96 | Peripheral request lines, group-major |
| ier_we_i | input | 1 | Source-enable byte write strobe |
| ier_line_i | input | 4 | Line (1..12) whose enable byte is written |
| ier_data_i | input | 8 | New enable byte |
| ack_we_i | input | 1 | Acknowledge clear strobe |
| ack_data_i | input | 12 | A 1 clears the acknowledge bit of that group |
| vec_we_i | input | 1 | Vector table write strobe |
| vec_idx_i | input | 7 | Vector table index |
| vec_data_i | input | 32 | Vector table write data |
| fetch_i | input | 1 | Vector fetch request |
| fetch_line_i | input | 4 | Line number (1..12) being fetched |
| trap_i | input | 1 | Software trap request |
| trap_num_i | input | 4 | Trap number |
| tint1_i | input | 1 | Timer 1 interrupt |
| tint2_i | input | 1 | Timer 2 interrupt |
| xnmi_i | input | 1 | External non-maskable input |
| int13_sel_i | input | 1 | Line 13 source select (1 = external) |
| cpu_int_o | output | 12 | Grouped CPU interrupt lines 1..12 |
| int13_o | output | 1 | CPU line 13 |
| int14_o | output | 1 | CPU line 14 |
| nmi_o | output | 1 | CPU NMI line |
| vec_o | output | 32 | Returned vector address |
| vec_vld_o | output | 1 | `vec_o` valid, one-cycle pulse |
| trap_bad_o | output | 1 | Invalid trap number, one-cycle pulse |

## Verification
The hardest situation to reach is a request line held high across a fetch and an acknowledge clear. The flag must not come back from a level, only from an edge. The bench therefore keeps two sources of one group high, fetches both in priority order, reopens the group twice, and checks that the line stays low until the request is dropped and raised again. The global-disable path is reached the same way: a pending, unacknowledged group is left standing while the enable drops, so the bench can see that the line, fetches and traps are muted and that the pending state comes back intact.

// File: rtl/pie_pkg.sv
package pie_pkg;
  localparam int unsigned DEF_GRP_N = 12;
  localparam int unsigned DEF_GRP_W = 8;
  localparam int unsigned DEF_VEC_W = 32;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_FETCH = 2'd1,
    RSP_TRAP  = 2'd2,
    RSP_BAD   = 2'd3
  } rsp_e;
endpackage

// File: rtl/pie_src_flags.sv
module pie_src_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  input  logic         ier_we_i,
  input  logic [W-1:0] ier_d_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] ier_o
);
  logic [W-1:0] req_q, flag_q, ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      flag_q <= '0;
      ier_q  <= '0;
    end else begin
      req_q  <= req_i;
      // new edge wins over a same-cycle clear
      flag_q <= (flag_q & ~clr_i) | (req_i & ~req_q);
      if (ier_we_i) ier_q <= ier_d_i;
    end
  end

  assign flag_o = flag_q;
  assign ier_o  = ier_q;
endmodule

// File: rtl/pie_prio.sv
module pie_prio #(
  parameter  int unsigned W   = 8,
  localparam int unsigned IDW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]   req_i,
  output logic           any_o,
  output logic [IDW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/pie_vec_table.sv
module pie_vec_table #(
  parameter  int unsigned N  = 96,
  parameter  int unsigned DW = 32,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) mem_q[i] <= '0;
    end else if (we_i && int'(wa_i) < int'(N)) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign rd_o = (int'(ra_i) < int'(N)) ? mem_q[ra_i] : '0;
endmodule

// File: rtl/pie_expander.sv
module pie_expander
  import pie_pkg::*;
#(
  parameter  int unsigned GRP_N  = DEF_GRP_N,
  parameter  int unsigned GRP_W  = DEF_GRP_W,
  parameter  int unsigned VEC_W  = DEF_VEC_W,
  localparam int unsigned SRC_N  = GRP_N * GRP_W,
  localparam int unsigned IDX_W  = $clog2(SRC_N),
  localparam int unsigned SEL_W  = (GRP_W > 1) ? $clog2(GRP_W) : 1,
  localparam int unsigned LINE_W = $clog2(GRP_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_en_i,
  input  logic [SRC_N-1:0]  irq_i,
  input  logic              ier_we_i,
  input  logic [LINE_W-1:0] ier_line_i,
  input  logic [GRP_W-1:0]  ier_data_i,
  input  logic              ack_we_i,
  input  logic [GRP_N-1:0]  ack_data_i,
  input  logic              vec_we_i,
  input  logic [IDX_W-1:0]  vec_idx_i,
  input  logic [VEC_W-1:0]  vec_data_i,
  input  logic              fetch_i,
  input  logic [LINE_W-1:0] fetch_line_i,
  input  logic              trap_i,
  input  logic [LINE_W-1:0] trap_num_i,
  input  logic              tint1_i,
  input  logic              tint2_i,
  input  logic              xnmi_i,
  input  logic              int13_sel_i,
  output logic [GRP_N-1:0]  cpu_int_o,
  output logic              int13_o,
  output logic              int14_o,
  output logic              nmi_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_vld_o,
  output logic              trap_bad_o
);
  function automatic logic line_ok(input logic [LINE_W-1:0] l);
    return (l != '0) && (int'(l) <= int'(GRP_N));
  endfunction

  logic [GRP_N-1:0] grp_any, ack_q, line_raw;
  logic [SEL_W-1:0] grp_idx  [GRP_N];
  logic [GRP_W-1:0] grp_flag [GRP_N];
  logic [GRP_W-1:0] grp_ier  [GRP_N];
  logic [GRP_W-1:0] grp_clr  [GRP_N];

  logic              f_ok, t_ok, do_fetch, do_trap;
  logic [LINE_W-1:0] f_g;
  logic [IDX_W-1:0]  rd_idx;
  logic [VEC_W-1:0]  rd_data;
  rsp_e              rsp_d;

  logic [VEC_W-1:0]  vec_q;
  logic              vld_q, bad_q;

  assign f_ok     = line_ok(fetch_line_i);
  assign f_g      = f_ok ? (fetch_line_i - LINE_W'(1)) : '0;
  assign line_raw = grp_any & ~ack_q;
  assign do_fetch = fetch_i && glb_en_i && f_ok && line_raw[f_g];

  assign t_ok     = line_ok(trap_num_i);
  assign do_trap  = trap_i && !fetch_i && glb_en_i;

  // per-group flags and priority
  for (genvar g = 0; g < int'(GRP_N); g++) begin : g_grp
    pie_src_flags #(.W(GRP_W)) u_flags (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (irq_i[g*GRP_W +: GRP_W]),
      .ier_we_i (ier_we_i && (ier_line_i == LINE_W'(g + 1))),
      .ier_d_i  (ier_data_i),
      .clr_i    (grp_clr[g]),
      .flag_o   (grp_flag[g]),
      .ier_o    (grp_ier[g])
    );

    pie_prio #(.W(GRP_W)) u_prio (
      .req_i (grp_flag[g] & grp_ier[g]),
      .any_o (grp_any[g]),
      .idx_o (grp_idx[g])
    );

    assign grp_clr[g] = (do_fetch && (f_g == LINE_W'(g)))
                      ? (GRP_W'(1) << grp_idx[g]) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 ack_q[g] <= 1'b0;
      else if (do_fetch && (f_g == LINE_W'(g)))    ack_q[g] <= 1'b1;
      else if (ack_we_i && ack_data_i[g])          ack_q[g] <= 1'b0;
    end
  end

  always_comb begin
    if (do_fetch)
      rd_idx = IDX_W'(f_g) * IDX_W'(GRP_W) + IDX_W'(grp_idx[f_g]);
    else
      rd_idx = (IDX_W'(trap_num_i) - IDX_W'(1)) * IDX_W'(GRP_W);
  end

  always_comb begin
    if (do_fetch)     rsp_d = RSP_FETCH;
    else if (do_trap) rsp_d = t_ok ? RSP_TRAP : RSP_BAD;
    else              rsp_d = RSP_NONE;
  end

  pie_vec_table #(.N(SRC_N), .DW(VEC_W)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (vec_we_i),
    .wa_i   (vec_idx_i),
    .wd_i   (vec_data_i),
    .ra_i   (rd_idx),
    .rd_o   (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      vld_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      vld_q <= (rsp_d == RSP_FETCH) || (rsp_d == RSP_TRAP);
      bad_q <= (rsp_d == RSP_BAD);
      if ((rsp_d == RSP_FETCH) || (rsp_d == RSP_TRAP)) vec_q <= rd_data;
    end
  end

  assign cpu_int_o  = glb_en_i ? line_raw : '0;
  assign int13_o    = int13_sel_i ? xnmi_i : tint1_i;
  assign int14_o    = tint2_i;
  assign nmi_o      = xnmi_i;
  assign vec_o      = vec_q;
  assign vec_vld_o  = vld_q;
  assign trap_bad_o = bad_q;
endmodule

// File: rtl/pie_expander_chk.sv
module pie_expander_chk #(
  parameter int unsigned GRP_N  = 12,
  parameter int unsigned LINE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              glb_en_i,
  input logic              ack_we_i,
  input logic              fetch_i,
  input logic [LINE_W-1:0] fetch_line_i,
  input logic              trap_i,
  input logic [LINE_W-1:0] trap_num_i,
  input logic [GRP_N-1:0]  cpu_int_o,
  input logic              vec_vld_o,
  input logic              trap_bad_o
);
  logic              hit_q;
  logic [LINE_W-1:0] hit_line_q;
  logic              fetch_ok_line;

  assign fetch_ok_line = (fetch_line_i != '0) && (int'(fetch_line_i) <= int'(GRP_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q      <= 1'b0;
      hit_line_q <= '0;
    end else begin
      hit_q      <= fetch_i && glb_en_i && fetch_ok_line && !ack_we_i
                    && cpu_int_o[fetch_ok_line ? int'(fetch_line_i) - 1 : 0];
      hit_line_q <= fetch_line_i;
    end
  end

  // R4 R5
  fetch_served_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> (vec_vld_o && !cpu_int_o[int'(hit_line_q) - 1]));

  // R7
  trap_zero_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && !fetch_i && glb_en_i && trap_num_i == '0) |=> (trap_bad_o && !vec_vld_o));

  // R8
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |-> (cpu_int_o == '0));

  // R8
  off_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> (!vec_vld_o && !trap_bad_o));

  // R6 R7
  rsp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vec_vld_o, trap_bad_o}));
endmodule

bind pie_expander pie_expander_chk #(.GRP_N(GRP_N), .LINE_W(LINE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .glb_en_i     (glb_en_i),
  .ack_we_i     (ack_we_i),
  .fetch_i      (fetch_i),
  .fetch_line_i (fetch_line_i),
  .trap_i       (trap_i),
  .trap_num_i   (trap_num_i),
  .cpu_int_o    (cpu_int_o),
  .vec_vld_o    (vec_vld_o),
  .trap_bad_o   (trap_bad_o)
);

// File: tb/tb_pie_expander.sv
module tb_pie_expander;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        glb_en_i = 1'b0;
  logic [95:0] irq_i = '0;
  logic        ier_we_i = 1'b0;
  logic [3:0]  ier_line_i = '0;
  logic [7:0]  ier_data_i = '0;
  logic        ack_we_i = 1'b0;
  logic [11:0] ack_data_i = '0;
  logic        vec_we_i = 1'b0;
  logic [6:0]  vec_idx_i = '0;
  logic [31:0] vec_data_i = '0;
  logic        fetch_i = 1'b0;
  logic [3:0]  fetch_line_i = '0;
  logic        trap_i = 1'b0;
  logic [3:0]  trap_num_i = '0;
  logic        tint1_i = 1'b0, tint2_i = 1'b0, xnmi_i = 1'b0, int13_sel_i = 1'b0;
  logic [11:0] cpu_int_o;
  logic        int13_o, int14_o, nmi_o, vec_vld_o, trap_bad_o;
  logic [31:0] vec_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pie_expander dut (.*);

  function automatic logic [31:0] vpat(int i);
    return 32'hC0DE_0000 + 32'(i * 273);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic raise(int line, int src);
    irq_i[(line-1)*8+src] = 1'b1; cyc();
  endtask

  task automatic drop(int line, int src);
    irq_i[(line-1)*8+src] = 1'b0; cyc();
  endtask

  task automatic set_ier(int line, logic [7:0] v);
    ier_we_i = 1; ier_line_i = 4'(line); ier_data_i = v; cyc(); ier_we_i = 0;
  endtask

  task automatic ack(logic [11:0] m);
    ack_we_i = 1; ack_data_i = m; cyc(); ack_we_i = 0; ack_data_i = '0;
  endtask

  task automatic fetch(int line);
    fetch_i = 1; fetch_line_i = 4'(line); cyc(); fetch_i = 0;
  endtask

  task automatic trap(int n);
    trap_i = 1; trap_num_i = 4'(n); cyc(); trap_i = 0;
  endtask

  task automatic t_reset();
    chk(cpu_int_o == 0 && !vec_vld_o && !trap_bad_o, "R1", {20'd0, cpu_int_o}, 0);
    glb_en_i = 1; trap(1);
    chk(vec_vld_o && vec_o == 0, "R1 table cleared", vec_o, 0);
    glb_en_i = 0;
  endtask

  task automatic t_table();
    for (int i = 0; i < 96; i++) begin
      vec_we_i = 1; vec_idx_i = 7'(i); vec_data_i = vpat(i); cyc();
    end
    vec_idx_i = 7'd100; vec_data_i = 32'hDEAD_BEEF; cyc();
    vec_we_i = 0;
    glb_en_i = 1;
    for (int n = 1; n <= 12; n++) begin
      trap(n);
      chk(vec_vld_o && vec_o == vpat((n-1)*8), "R11", vec_o, vpat((n-1)*8));
    end
  endtask

  task automatic t_line();
    set_ier(1, 8'hFF); set_ier(3, 8'hFF); set_ier(4, 8'h00);
    set_ier(6, 8'hFF); set_ier(12, 8'h80);
    raise(3, 5);
    chk(cpu_int_o == 12'h004, "R2 R3 edge sets line", {20'd0, cpu_int_o}, 32'h004);
    raise(4, 1);
    chk(cpu_int_o == 12'h004, "R3 disabled source", {20'd0, cpu_int_o}, 32'h004);
  endtask

  task automatic t_prio();
    raise(3, 2);
    fetch(3);
    chk(vec_vld_o && vec_o == vpat(18), "R4 lowest wins", vec_o, vpat(18));
    chk(cpu_int_o[2] == 0, "R5 ack blocks", {31'd0, cpu_int_o[2]}, 0);
    cyc();
    chk(!vec_vld_o, "R4 one-cycle pulse", {31'd0, vec_vld_o}, 0);
    ack(12'h001);
    chk(cpu_int_o[2] == 0, "R5 zero write keeps ack", {31'd0, cpu_int_o[2]}, 0);
    ack(12'h004);
    chk(cpu_int_o[2] == 1, "R5 ack cleared", {31'd0, cpu_int_o[2]}, 1);
    fetch(3);
    chk(vec_vld_o && vec_o == vpat(21), "R4 next source", vec_o, vpat(21));
    ack(12'h004);
    chk(cpu_int_o[2] == 0, "R2 held level no reflag", {31'd0, cpu_int_o[2]}, 0);
    drop(3, 5); drop(3, 2); raise(3, 5);
    chk(cpu_int_o[2] == 1, "R2 new edge", {31'd0, cpu_int_o[2]}, 1);
    fetch(3); ack(12'h004); drop(3, 5);
    raise(12, 7);
    fetch(12);
    chk(vec_vld_o && vec_o == vpat(95), "R4 last entry", vec_o, vpat(95));
    ack(12'h800); drop(12, 7);
  endtask

  task automatic t_trap();
    raise(1, 4);
    trap(2);
    chk(vec_vld_o && vec_o == vpat(8), "R6 trap 2", vec_o, vpat(8));
    trap(12);
    chk(vec_vld_o && vec_o == vpat(88), "R6 trap 12", vec_o, vpat(88));
    chk(cpu_int_o[0] == 1, "R6 trap leaves flags", {31'd0, cpu_int_o[0]}, 1);
    trap(0);
    chk(trap_bad_o && !vec_vld_o, "R7 trap 0", {30'd0, trap_bad_o, vec_vld_o}, 32'h2);
    trap(13);
    chk(trap_bad_o && !vec_vld_o, "R7 trap 13", {30'd0, trap_bad_o, vec_vld_o}, 32'h2);
    cyc();
    chk(!trap_bad_o, "R7 one-cycle pulse", {31'd0, trap_bad_o}, 0);
  endtask

  task automatic t_disable();
    glb_en_i = 0; cyc();
    chk(cpu_int_o == 0, "R8 lines low", {20'd0, cpu_int_o}, 0);
    trap(3);
    chk(!vec_vld_o && !trap_bad_o, "R8 trap muted", {30'd0, trap_bad_o, vec_vld_o}, 0);
    trap(0);
    chk(!vec_vld_o && !trap_bad_o, "R8 trap 0 muted", {30'd0, trap_bad_o, vec_vld_o}, 0);
    fetch(1);
    chk(!vec_vld_o, "R8 fetch muted", {31'd0, vec_vld_o}, 0);
    glb_en_i = 1; cyc();
    chk(cpu_int_o[0] == 1, "R8 pending kept", {31'd0, cpu_int_o[0]}, 1);
    fetch(1);
    chk(vec_vld_o && vec_o == vpat(4), "R8 fetch after enable", vec_o, vpat(4));
    ack(12'h001); drop(1, 4);
  endtask

  task automatic t_empty();
    fetch(6);
    chk(!vec_vld_o && !trap_bad_o, "R10 empty fetch", {31'd0, vec_vld_o}, 0);
    fetch(0);
    chk(!vec_vld_o, "R10 line 0 fetch", {31'd0, vec_vld_o}, 0);
    raise(6, 0);
    chk(cpu_int_o[5] == 1, "R10 ack untouched", {31'd0, cpu_int_o[5]}, 1);
    fetch(6);
    chk(vec_vld_o && vec_o == vpat(40), "R10 later fetch", vec_o, vpat(40));
    fetch(6);
    chk(!vec_vld_o, "R10 acked fetch", {31'd0, vec_vld_o}, 0);
    ack(12'h020); drop(6, 0);
  endtask

  task automatic t_mux();
    tint1_i = 1; xnmi_i = 0; tint2_i = 0; int13_sel_i = 0; #1;
    chk(int13_o == 1 && nmi_o == 0 && int14_o == 0, "R9 timer1 path",
        {29'd0, int13_o, nmi_o, int14_o}, 32'h4);
    int13_sel_i = 1; #1;
    chk(int13_o == 0, "R9 external path", {31'd0, int13_o}, 0);
    xnmi_i = 1; tint1_i = 0; tint2_i = 1; #1;
    chk(int13_o == 1 && nmi_o == 1 && int14_o == 1, "R9 all high",
        {29'd0, int13_o, nmi_o, int14_o}, 32'h7);
    tint2_i = 0; xnmi_i = 0; #1;
    chk(int14_o == 0 && nmi_o == 0, "R9 follow low", {30'd0, int14_o, nmi_o}, 0);
    cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1; cyc();
    t_reset();
    t_table();
    t_line();
    t_prio();
    t_trap();
    t_disable();
    t_empty();
    t_mux();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule